// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM Generator

This block produces two independent pulse-width waveforms. Each channel's waveform is set by two 16-bit counts packed into one 32-bit word. The output stays high for the high count, then low for the low count, and then the pattern repeats. The counts are measured in ticks of a per-channel prescaled clock. That clock is built in three steps. First, one of four source tick strobes is selected. Second, an integer divider of 1 to 128 is applied. Third, a clock-enable gate passes or blocks the result.

Software programs the block through a small 32-bit register interface: one count word per channel and one shared control word. Writes complete in the cycle they are presented and reads return data combinationally, so the interface has no back-pressure and no ready signal. The four clock sources are single-cycle enable strobes in the system clock domain. There is no polarity control. To get an inverted waveform, software swaps the high and low counts.

Top module: `dual_hilo_pwm`

## Requirements
- R1: Word offsets are 0x0 for channel A's count word, 0x4 for channel B's count word and 0x8 for the control word. A write to one of these offsets is visible on a read of the same offset. After reset all three words read 0 and both outputs are low.
- R2: In a count word, bits 31:16 hold the high count H and bits 15:0 hold the low count L. An enabled channel drives its output high for H prescaled ticks, then low for L prescaled ticks, and repeats.
- R3: The control word fields are:
  - channel A: output enable at bit 0, source select at bits 5:4, divider at bits 14:8, clock enable at bit 15;
  - channel B: output enable at bit 1, source select at bits 7:6, divider at bits 22:16, clock enable at bit 23.
  One prescaled tick occurs every (divider+1) ticks of the selected source.
- R4: A source select value of s makes the channel count strobes from src_tick[s].
- R5: While a channel's clock enable is clear, its counter receives no ticks and its output holds its level.
- R6: A high count of 0 keeps the enabled output constantly low.
- R7: A low count of 0 still gives a low phase of exactly one prescaled tick in each period.
- R8: Clearing a channel's output enable forces that output low in the next cycle, whatever phase it was in.
- R9: A new count word takes effect only when the current period ends. A write that lands on the same clock edge as a period end first applies to the period after the next one.
- R10: Setting a channel's output enable starts a period in the high phase, with the counter and the prescaler both freshly cleared.
- R11: The two channels run independently, each with its own source, divider and counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, captured on the rising clock edge |
| bus_addr | input | 4 | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_tick | input | 4 | Single-cycle strobes of the four clock sources |
| pwm_out | output | 2 | Waveform outputs, bit 0 channel A, bit 1 channel B |

## Verification
Two functions can fall on the same clock edge: a count-word write and the end of a period, where the channel reloads its active counts. The bench provokes this by counting cycles from an observed rising edge of the output, so that the write strobe is captured exactly on the edge that ends the period. It then judges the result by measuring the phase lengths that follow. The next period must still use the old counts and the period after it the new ones. A second coincidence, a write mid-phase, is also checked: it must leave the running high phase at its old length.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = DATA_W / 2;
  localparam int DIV_W   = 7;
  localparam int SEL_W   = 2;
  localparam int NUM_SRC = 1 << SEL_W;
  localparam int NUM_CH  = 2;
  localparam int ADDR_W  = 4;

  typedef struct packed {
    logic             oe;
    logic             clk_en;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  cnt_hi [NUM_CH],
  output logic [CNT_W-1:0]  cnt_lo [NUM_CH],
  output ch_cfg_t           cfg    [NUM_CH]
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [DATA_W-1:0] cnt_q [NUM_CH];
  logic [DATA_W-1:0] ctrl_q;
  logic [WIDX_W-1:0] widx;
  logic              aligned;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int i = 0; i < NUM_CH; i++) cnt_q[i] <= '0;
    end else if (bus_wr && aligned) begin
      for (int i = 0; i < NUM_CH; i++)
        if (widx == WIDX_W'(i)) cnt_q[i] <= bus_wdata;
      if (widx == WIDX_W'(NUM_CH)) ctrl_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int i = 0; i < NUM_CH; i++)
        if (widx == WIDX_W'(i)) bus_rdata = cnt_q[i];
      if (widx == WIDX_W'(NUM_CH)) bus_rdata = ctrl_q;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign cnt_hi[g]     = cnt_q[g][2*CNT_W-1:CNT_W];
    assign cnt_lo[g]     = cnt_q[g][CNT_W-1:0];
    assign cfg[g].oe     = ctrl_q[g];
    assign cfg[g].sel    = ctrl_q[4+SEL_W*g +: SEL_W];
    assign cfg[g].div    = ctrl_q[8+8*g +: DIV_W];
    assign cfg[g].clk_en = ctrl_q[15+8*g];
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  input  logic [DIV_W-1:0]   div,
  output logic               tick
);
  logic [DIV_W-1:0] div_cnt;
  logic             src_hit;
  logic             wrap;

  assign src_hit = src_tick[sel];
  assign wrap    = (div_cnt >= div);
  assign tick    = run && src_hit && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      div_cnt <= '0;
    else if (src_hit)
      div_cnt <= wrap ? '0 : div_cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_hilo_gen.sv
module pwm_hilo_gen
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  output logic             wave
);
  logic [CNT_W-1:0] cur_hi, cur_lo, cnt, cnt_nx;
  logic             in_high;
  logic             hi_done, lo_done;

  assign cnt_nx  = cnt + 1'b1;
  assign hi_done = (cur_hi == '0) || (cnt_nx >= cur_hi);
  assign lo_done = (cur_lo == '0) || (cnt_nx >= cur_lo);
  assign wave    = en && in_high && (cur_hi != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_hi  <= '0;
      cur_lo  <= '0;
      cnt     <= '0;
      in_high <= 1'b1;
    end else if (!en) begin
      cur_hi  <= hi_in;
      cur_lo  <= lo_in;
      cnt     <= '0;
      in_high <= 1'b1;
    end else if (tick) begin
      if (in_high) begin
        if (hi_done) begin
          in_high <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt_nx;
        end
      end else if (lo_done) begin
        in_high <= 1'b1;
        cnt     <= '0;
        cur_hi  <= hi_in;
        cur_lo  <= lo_in;
      end else begin
        cnt <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/dual_hilo_pwm.sv
module dual_hilo_pwm
  import pwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic [NUM_CH-1:0]  pwm_out
);
  logic [CNT_W-1:0]  cnt_hi [NUM_CH];
  logic [CNT_W-1:0]  cnt_lo [NUM_CH];
  ch_cfg_t           cfg    [NUM_CH];
  logic [NUM_CH-1:0] ch_oe, ch_clken, ch_tick;

  pwm_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .cfg(cfg)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_oe[g]    = cfg[g].oe;
    assign ch_clken[g] = cfg[g].clk_en;

    pwm_prescaler u_pre (
      .clk(clk), .rst_n(rst_n), .run(cfg[g].oe && cfg[g].clk_en),
      .src_tick(src_tick), .sel(cfg[g].sel), .div(cfg[g].div),
      .tick(ch_tick[g])
    );

    pwm_hilo_gen u_gen (
      .clk(clk), .rst_n(rst_n), .en(cfg[g].oe), .tick(ch_tick[g]),
      .hi_in(cnt_hi[g]), .lo_in(cnt_lo[g]), .wave(pwm_out[g])
    );
  end
endmodule

// File: rtl/dual_hilo_pwm_chk.sv
module dual_hilo_pwm_chk
  import pwm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NUM_CH-1:0] wdata_oe,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] ch_oe,
  input logic [NUM_CH-1:0] ch_clken,
  input logic [NUM_CH-1:0] ch_tick
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(4*NUM_CH));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R8
    disable_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !wdata_oe[g]) |=> !pwm_out[g]);

    // R8
    high_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_out[g] |-> ch_oe[g]);

    // R5
    gate_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_clken[g] |-> !ch_tick[g]);

    // R5
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_clken[g] && !ctrl_wr) |=> $stable(pwm_out[g]));

    // R10
    rise_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[g]) |-> ch_oe[g]);
  end
endmodule

bind dual_hilo_pwm dual_hilo_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata_oe(bus_wdata[1:0]), .pwm_out(pwm_out), .ch_oe(ch_oe),
  .ch_clken(ch_clken), .ch_tick(ch_tick)
);

// File: tb/tb_dual_hilo_pwm.sv
`timescale 1ns/1ps
module tb_dual_hilo_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick;
  logic [1:0]  pwm_out;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  localparam logic [3:0] A_CNT = 4'h0, B_CNT = 4'h4, CTRL = 4'h8;
  localparam logic [31:0] A_ON = 32'h0000_8001;
  localparam logic [31:0] B_ON = 32'h0080_0002;

  always #5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;
  assign src_tick = {cyc % 5 == 0, cyc % 3 == 0, cyc % 2 == 0, 1'b1};

  dual_hilo_pwm dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    int   g;
    g = 0;
    prev = pwm_out[ch];
    @(negedge clk);
    while (!(!prev && pwm_out[ch]) && g < 100000) begin
      prev = pwm_out[ch];
      @(negedge clk);
      g++;
    end
  endtask

  task automatic run_len(input int ch, output int n);
    logic lv;
    lv = pwm_out[ch];
    n = 0;
    while (pwm_out[ch] == lv && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 reset out", pwm_out, 0);
    rd(A_CNT, d); check("R1 reset A count", d, 0);
    rd(B_CNT, d); check("R1 reset B count", d, 0);
    rd(CTRL, d);  check("R1 reset ctrl", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(A_CNT, 32'h1234_0abc);
    wr(B_CNT, 32'h00fe_5501);
    wr(CTRL, 32'h0012_3450);
    rd(A_CNT, d); check("R1 readback A", d, 32'h1234_0abc);
    rd(B_CNT, d); check("R1 readback B", d, 32'h00fe_5501);
    rd(CTRL, d);  check("R1 readback ctrl", d, 32'h0012_3450);
    wr(CTRL, 0);
  endtask

  task automatic t_basic();
    int n;
    wr(A_CNT, 32'h0003_0002);
    wr(CTRL, A_ON);
    wait_rise(0);
    run_len(0, n); check("R2 high length", n, 3);
    run_len(0, n); check("R2 low length", n, 2);
    wr(CTRL, 0);
  endtask

  task automatic t_div();
    int n;
    wr(A_CNT, 32'h0003_0002);
    wr(CTRL, A_ON | (32'd2 << 8));
    wait_rise(0);
    run_len(0, n); check("R3 divided high", n, 9);
    run_len(0, n); check("R3 divided low", n, 6);
    wr(CTRL, 0);
  endtask

  task automatic t_sel();
    int n;
    wr(A_CNT, 32'h0002_0003);
    wr(CTRL, A_ON | (32'd2 << 4) | (32'd1 << 8));
    wait_rise(0);
    run_len(0, n); check("R4 source 2 high", n, 12);
    run_len(0, n); check("R4 source 2 low", n, 18);
    wr(CTRL, 0);
  endtask

  task automatic t_enable_start();
    int n;
    wr(A_CNT, 32'h0004_0003);
    wr(CTRL, A_ON | (32'd1 << 8));
    check("R10 high right after enable", pwm_out[0], 1);
    run_len(0, n); check("R10 first high full length", n, 8);
    run_len(0, n); check("R10 first low", n, 6);
  endtask

  task automatic t_disable();
    wait_rise(0);
    @(negedge clk);
    wr(CTRL, 0);
    check("R8 output low after disable", pwm_out[0], 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R8 stays low", pwm_out[0], 0);
    end
  endtask

  task automatic t_hi_zero();
    int highs;
    highs = 0;
    wr(A_CNT, 32'h0000_0003);
    wr(CTRL, A_ON);
    for (int i = 0; i < 30; i++) begin
      if (pwm_out[0]) highs++;
      @(negedge clk);
    end
    check("R6 high samples with zero high count", highs, 0);
    wr(CTRL, 0);
  endtask

  task automatic t_lo_zero();
    int n;
    wr(A_CNT, 32'h0005_0000);
    wr(CTRL, A_ON);
    wait_rise(0);
    run_len(0, n); check("R7 high with zero low count", n, 5);
    run_len(0, n); check("R7 low is one tick", n, 1);
    wr(CTRL, 0);
  endtask

  task automatic t_gate();
    int n, bad;
    bad = 0;
    wr(A_CNT, 32'h0004_0004);
    wr(CTRL, A_ON);
    wait_rise(0);
    wr(CTRL, 32'h0000_0001);
    for (int i = 0; i < 20; i++) begin
      if (!pwm_out[0]) bad++;
      @(negedge clk);
    end
    check("R5 output held while gated", bad, 0);
    wr(CTRL, A_ON);
    run_len(0, n);
    run_len(0, n); check("R5 low after resume", n, 4);
    wr(CTRL, 0);
  endtask

  task automatic t_mid_write();
    int n;
    wr(A_CNT, 32'h0004_0004);
    wr(CTRL, A_ON);
    wait_rise(0);
    bus_wr = 1'b1; bus_addr = A_CNT; bus_wdata = 32'h0002_0006;
    @(negedge clk);
    bus_wr = 1'b0;
    run_len(0, n); check("R9 running high unchanged", n, 3);
    run_len(0, n); check("R9 running low unchanged", n, 4);
    run_len(0, n); check("R9 new high", n, 2);
    run_len(0, n); check("R9 new low", n, 6);
    wr(CTRL, 0);
  endtask

  task automatic t_boundary();
    int n;
    wr(A_CNT, 32'h0003_0003);
    wr(CTRL, A_ON);
    wait_rise(0);
    repeat (5) @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_CNT; bus_wdata = 32'h0001_0002;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 boundary period started", pwm_out[0], 1);
    run_len(0, n); check("R9 boundary keeps old high", n, 3);
    run_len(0, n); check("R9 boundary keeps old low", n, 3);
    run_len(0, n); check("R9 boundary then new high", n, 1);
    run_len(0, n); check("R9 boundary then new low", n, 2);
    wr(CTRL, 0);
  endtask

  task automatic t_chan_b();
    int n;
    wr(A_CNT, 32'h0003_0002);
    wr(B_CNT, 32'h0002_0005);
    wr(CTRL, A_ON | B_ON | (32'd3 << 6));
    wait_rise(1);
    run_len(1, n); check("R11 channel B high", n, 10);
    run_len(1, n); check("R11 channel B low", n, 25);
    wait_rise(0);
    run_len(0, n); check("R11 channel A high alongside B", n, 3);
    run_len(0, n); check("R11 channel A low alongside B", n, 2);
    wr(CTRL, A_ON);
    check("R11 B off, A unaffected", pwm_out[1], 0);
    wr(CTRL, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #150000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_basic();
    t_div();
    t_sel();
    t_enable_start();
    t_disable();
    t_hi_zero();
    t_lo_zero();
    t_gate();
    t_mid_write();
    t_boundary();
    t_chan_b();
    finish_run();
  end
endmodule